// File: doc/BRIEF.md
# Handshake Property Monitor

This block is a synthesizable checker that sits beside a design and watches four single-bit signals on that design's clock: a request, an acknowledge, a halt and a grant. It checks two timing rules on them while the chip runs and reports each violation as a one-cycle failure pulse. A shared sticky error flag records that at least one violation has occurred.

The grant rule has a trigger: a request in one cycle, an acknowledge in the next, and halt low in the cycle after that. Once the trigger completes, grant must be high in that last trigger cycle and in the cycle that follows it. If the trigger does not complete, nothing is owed. The latency rule says that each cycle with request high must see acknowledge high in the same cycle or in one of the next two cycles.

A new attempt of each rule starts in every cycle. Each attempt moves down its own chain of pipeline stages, so attempts that overlap in time are judged independently of each other. Both the grant hold length and the latency window are parameters. The default values give the rules described above.

Top module: `hs_prop_monitor`

## Requirements
- R1: If req=1 at sample n, ack=1 at sample n+1, halt=0 at sample n+2 and grant=0 at sample n+2, then grant_seq_fail is high for the clock period after edge n+2.
- R2: If the trigger of R1 completes at sample n+2 with grant=1 there, and grant=0 at sample n+3, then grant_seq_fail is high for the clock period after edge n+3.
- R3: No grant_seq_fail is raised when the trigger does not complete: req low at n, ack low at n+1, or halt high at n+2. In that case grant is not checked.
- R4: If req=1 at sample n and ack=0 at samples n, n+1 and n+2, then ack_late_fail is high for the clock period after edge n+2. An ack at n+1 or n+2 prevents this.
- R5: An ack sampled in the same cycle as the req satisfies that request, and no ack_late_fail follows from it.
- R6: Attempts begin at every sample and are judged independently. With back-to-back requests or triggers, each start cycle produces its own pass or fail.
- R7: Each failure pulse is registered. It is high only in the clock periods that follow a sample that decides a failure, and it is low otherwise.
- R8: err_sticky goes high on the same edge as any failure pulse. It stays high until reset.
- R9: A synchronous active-high rst clears every attempt in flight, both pulses and err_sticky. Attempts that started before the reset edge never fail afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the watched design |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Watched request signal |
| ack | input | 1 | Watched acknowledge signal |
| halt | input | 1 | Watched halt signal |
| grant | input | 1 | Watched grant signal |
| grant_seq_fail | output | 1 | Pulse: grant rule violated |
| ack_late_fail | output | 1 | Pulse: acknowledge latency rule violated |
| err_sticky | output | 1 | Set on any violation, cleared only by reset |

## Verification
A stage bit that is stuck or lost shows up at the ports as a pulse that appears or goes missing within one to three cycles of the stimulus that should have used it. err_sticky then records a spurious pulse for good. A stage that reset fails to clear fires a pulse in the first cycles after reset even though the input was idle. Because of this, the bench compares every output on every cycle, and it runs long stretches of random traffic with dense overlapping attempts as well as resets in the middle of a run.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int DEF_GRANT_HOLD = 2;
  localparam int DEF_LAT_WIN    = 2;
  localparam int NUM_PROPS      = 2;

  // An obligation to see grant high that is not met
  function automatic logic grant_miss(input logic obliged, input logic grant_now);
    return obliged & ~grant_now;
  endfunction

  // The oldest pending request reaches the end of its window without ack
  function automatic logic window_expired(input logic oldest_pending, input logic ack_now);
    return oldest_pending & ~ack_now;
  endfunction
endpackage

// File: rtl/hs_seq_grant_chk.sv
module hs_seq_grant_chk
  import hs_mon_pkg::*;
#(
  parameter int GRANT_HOLD = DEF_GRANT_HOLD
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic halt,
  input  logic grant,
  output logic match_o,
  output logic miss_o,
  output logic fail_pulse_o
);
  logic req_seen_q;
  logic ack_seen_q;
  logic [GRANT_HOLD-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen_q <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      req_seen_q <= req;
      ack_seen_q <= req_seen_q & ack;
    end
  end

  assign match_o = ack_seen_q & ~halt;

  generate
    if (GRANT_HOLD == 1) begin : g_single
      assign live = match_o;
    end else begin : g_hold
      logic [GRANT_HOLD-2:0] held_q;
      assign live = {held_q, match_o};
      always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= live[GRANT_HOLD-2:0] & {(GRANT_HOLD-1){grant}};
      end
    end
  endgenerate

  assign miss_o = grant_miss(|live, grant);

  always_ff @(posedge clk) begin
    if (rst) fail_pulse_o <= 1'b0;
    else     fail_pulse_o <= miss_o;
  end
endmodule

// File: rtl/hs_req_ack_chk.sv
module hs_req_ack_chk
  import hs_mon_pkg::*;
#(
  parameter int LAT_WIN = DEF_LAT_WIN
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  output logic miss_o,
  output logic fail_pulse_o
);
  logic [LAT_WIN-1:0] pend_q;
  logic [LAT_WIN:0]   pend;

  assign pend = {pend_q, req};

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend[LAT_WIN-1:0] & {LAT_WIN{~ack}};
  end

  assign miss_o = window_expired(pend[LAT_WIN], ack);

  always_ff @(posedge clk) begin
    if (rst) fail_pulse_o <= 1'b0;
    else     fail_pulse_o <= miss_o;
  end
endmodule

// File: rtl/hs_err_latch.sv
module hs_err_latch #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] fail_i,
  output logic             err_o
);
  always_ff @(posedge clk) begin
    if (rst)          err_o <= 1'b0;
    else if (|fail_i) err_o <= 1'b1;
  end
endmodule

// File: rtl/hs_prop_monitor.sv
module hs_prop_monitor
  import hs_mon_pkg::*;
#(
  parameter int GRANT_HOLD = DEF_GRANT_HOLD,
  parameter int LAT_WIN    = DEF_LAT_WIN
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic halt,
  input  logic grant,
  output logic grant_seq_fail,
  output logic ack_late_fail,
  output logic err_sticky
);
  logic seq_match;
  logic seq_miss;
  logic late_miss;

  hs_seq_grant_chk #(.GRANT_HOLD(GRANT_HOLD)) u_seq (
    .clk(clk), .rst(rst), .req(req), .ack(ack), .halt(halt), .grant(grant),
    .match_o(seq_match), .miss_o(seq_miss), .fail_pulse_o(grant_seq_fail)
  );

  hs_req_ack_chk #(.LAT_WIN(LAT_WIN)) u_lat (
    .clk(clk), .rst(rst), .req(req), .ack(ack),
    .miss_o(late_miss), .fail_pulse_o(ack_late_fail)
  );

  hs_err_latch #(.N_SRC(NUM_PROPS)) u_err (
    .clk(clk), .rst(rst), .fail_i({late_miss, seq_miss}), .err_o(err_sticky)
  );
endmodule

// File: rtl/hs_prop_monitor_sva.sv
module hs_prop_monitor_sva #(
  parameter int GRANT_HOLD = 2,
  parameter int LAT_WIN    = 2
) (
  input logic clk,
  input logic rst,
  input logic req,
  input logic ack,
  input logic halt,
  input logic grant,
  input logic seq_match,
  input logic grant_seq_fail,
  input logic ack_late_fail,
  input logic err_sticky
);
  // non-reset edges seen since the last reset edge, saturating
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= 3'd0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  assert_sticky_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (grant_seq_fail || ack_late_fail) |-> err_sticky);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0) |-> (!grant_seq_fail && !ack_late_fail && !err_sticky));

  generate
    if (GRANT_HOLD == 2 && LAT_WIN == 2) begin : g_default_shape
      assert_match_origin_R3: assert property (@(posedge clk) disable iff (rst)
        seq_match |-> (cyc >= 3'd2 && $past(req, 2) && $past(ack, 1) && !halt));

      assert_grant_now_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3 && $past(req, 3) && $past(ack, 2) && !$past(halt, 1) && !$past(grant, 1))
        |-> grant_seq_fail);

      assert_grant_next_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd4 && $past(req, 4) && $past(ack, 3) && !$past(halt, 2) && $past(grant, 2)
         && !$past(grant, 1)) |-> grant_seq_fail);

      // R7: a pulse needs a deciding sample behind it
      assert_seq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        grant_seq_fail |->
          ((cyc >= 3'd3 && $past(req, 3) && $past(ack, 2) && !$past(halt, 1) && !$past(grant, 1)) ||
           (cyc >= 3'd4 && $past(req, 4) && $past(ack, 3) && !$past(halt, 2) && $past(grant, 2)
            && !$past(grant, 1))));

      assert_late_detect_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3 && $past(req, 3) && !$past(ack, 3) && !$past(ack, 2) && !$past(ack, 1))
        |-> ack_late_fail);

      // R5: an ack in the request cycle or later in the window rules out a pulse
      assert_late_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ack_late_fail |->
          (cyc >= 3'd3 && $past(req, 3) && !$past(ack, 3) && !$past(ack, 2) && !$past(ack, 1)));
    end
  endgenerate
endmodule

bind hs_prop_monitor hs_prop_monitor_sva #(.GRANT_HOLD(GRANT_HOLD), .LAT_WIN(LAT_WIN)) u_sva (
  .clk(clk), .rst(rst), .req(req), .ack(ack), .halt(halt), .grant(grant),
  .seq_match(seq_match), .grant_seq_fail(grant_seq_fail),
  .ack_late_fail(ack_late_fail), .err_sticky(err_sticky)
);

// File: tb/hs_prop_monitor_bench.sv
module hs_prop_monitor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, ack = 1'b0, halt = 1'b0, grant = 1'b0;
  logic grant_seq_fail, ack_late_fail, err_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  s;
    logic  l;
    logic  e;
    string tag;
  } exp_t;
  exp_t q[$];

  // history of samples: index 1 = previous sample
  logic hr [1:3];
  logic ha [1:3];
  logic hh [1:3];
  logic hg [1:3];
  logic sticky_m = 1'b0;

  hs_prop_monitor u_hs_prop_monitor (
    .clk(clk), .rst(rst), .req(req), .ack(ack), .halt(halt), .grant(grant),
    .grant_seq_fail(grant_seq_fail), .ack_late_fail(ack_late_fail), .err_sticky(err_sticky)
  );

  always #4 clk = ~clk;

  task automatic clear_hist();
    for (int i = 1; i <= 3; i++) begin
      hr[i] = 1'b0; ha[i] = 1'b0; hh[i] = 1'b0; hg[i] = 1'b0;
    end
    sticky_m = 1'b0;
  endtask

  // Driver: applies one sample and pushes the expected outputs for it
  task automatic step(input logic r, input logic a, input logic h, input logic g, input string tag);
    exp_t x;
    req = r; ack = a; halt = h; grant = g;
    @(posedge clk);
    // grant rule: trigger finishing now with grant low, or one sample ago and grant now low
    x.s = (hr[2] && ha[1] && !h && !g) || (hr[3] && ha[2] && !hh[1] && hg[1] && !g);
    // latency rule: request two samples ago with no ack in any of the three samples
    x.l = hr[2] && !ha[2] && !ha[1] && !a;
    sticky_m = sticky_m | x.s | x.l;
    x.e = sticky_m;
    x.tag = tag;
    for (int i = 3; i >= 2; i--) begin
      hr[i] = hr[i-1]; ha[i] = ha[i-1]; hh[i] = hh[i-1]; hg[i] = hg[i-1];
    end
    hr[1] = r; ha[1] = a; hh[1] = h; hg[1] = g;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    exp_t x;
    rst = 1'b1;
    @(posedge clk);
    clear_hist();
    x.s = 1'b0; x.l = 1'b0; x.e = 1'b0; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares outputs with the queued expectations
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (grant_seq_fail !== x.s) begin
        errors++;
        $display("FAIL %s grant_seq_fail actual %0b expected %0b", x.tag, grant_seq_fail, x.s);
      end
      checks++;
      if (ack_late_fail !== x.l) begin
        errors++;
        $display("FAIL %s ack_late_fail actual %0b expected %0b", x.tag, ack_late_fail, x.l);
      end
      checks++;
      if (err_sticky !== x.e) begin
        errors++;
        $display("FAIL %s err_sticky actual %0b expected %0b", x.tag, err_sticky, x.e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    do_reset("R9");
    idle(3, "R9");

    // R1 pass then fail
    step(1, 0, 0, 0, "R1"); step(0, 1, 0, 0, "R1"); step(0, 0, 0, 1, "R1"); step(0, 0, 0, 1, "R1");
    idle(2, "R1");
    step(1, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R1"); step(0, 0, 0, 0, "R1");
    idle(3, "R7");
    do_reset("R9");

    // R2: grant drops in the second cycle
    step(1, 1, 0, 0, "R2"); step(0, 1, 0, 0, "R2"); step(0, 0, 0, 1, "R2"); step(0, 0, 0, 0, "R2");
    idle(4, "R8");
    do_reset("R9");

    // R3: halt blocks trigger; missing ack blocks trigger
    step(1, 1, 0, 0, "R3"); step(0, 1, 0, 0, "R3"); step(0, 0, 1, 0, "R3"); step(0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, "R3"); step(0, 0, 0, 0, "R3"); step(0, 0, 0, 0, "R3"); step(0, 0, 0, 0, "R3");
    idle(2, "R3");

    // R5: same-cycle ack
    step(1, 1, 0, 0, "R5"); step(0, 0, 0, 0, "R5"); step(0, 0, 0, 0, "R5"); idle(2, "R5");

    // R4: ack late at n+2 passes, none at all fails
    step(1, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R4"); step(0, 1, 0, 0, "R4"); idle(2, "R4");
    step(1, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R4"); idle(2, "R7");
    do_reset("R9");

    // R6: overlapping requests and triggers
    step(1, 0, 0, 1, "R6"); step(1, 0, 0, 1, "R6"); step(1, 1, 0, 1, "R6"); step(1, 0, 0, 1, "R6");
    step(1, 1, 0, 1, "R6"); step(1, 1, 0, 0, "R6"); step(0, 1, 0, 1, "R6"); step(0, 0, 0, 0, "R6");
    idle(4, "R6");

    // R9: reset with attempts in flight
    step(1, 1, 0, 1, "R9"); step(1, 1, 0, 1, "R9");
    do_reset("R9");
    step(0, 0, 0, 0, "R9"); step(0, 0, 0, 0, "R9"); idle(3, "R9");

    // R6: random overlapping traffic with occasional resets
    for (int i = 0; i < 4000; i++) begin
      if (i % 700 == 699) do_reset("R9");
      else step(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                ($urandom % 5) != 0, "R6");
    end
    idle(4, "R8");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule